// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts processor activity for profiling. It holds one free-running cycle counter and a small bank of event counters. Each event counter is pointed at one of the incoming event pulse lines, or at a software-driven increment, through a per-counter event code. All state is reached through a simple single-cycle register bus with valid, write, address and data. Reads return data in the same cycle. Writes take effect at the next rising clock edge.

Counting enables and overflow-interrupt enables are each managed through a pair of registers. Writing ones to one register of the pair sets bits, and writing ones to the other clears them. The event code and the count value of an event counter are reached indirectly, through a selection register. Overflows are latched in a flag register that software clears by writing ones. A single interrupt line reports any flagged overflow whose interrupt is enabled. A privilege input together with a user-access register decides whether unprivileged code may use the unit.

Register map (4-bit address): 0 control, 1 enable-set, 2 enable-clear, 3 overflow flags, 4 software increment, 5 counter select, 6 cycle count, 7 event code of the selected counter, 8 count of the selected counter, 9 user access, 10 interrupt-enable set, 11 interrupt-enable clear. In every mask register, bits 3..0 stand for event counters 3..0 and bit 4 stands for the cycle counter.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, all counters, enables, overflow flags, interrupt enables, the select register, the event codes and the user-access bit are zero, and irq is low.
- R2: A write to address 1 sets each enable bit written as 1. A write to address 2 clears each enable bit written as 1. Reading either address returns the current enable mask.
- R3: The cycle counter advances by one on every clock edge at which control bit 0 (global enable) and enable bit 4 are both set, and holds otherwise.
- R4: Event counter i advances by one on each edge at which the global enable and enable bit i are set and event_in[k-1] is high, where k (1 to 8) is its event code. Code 0 and codes above 8 ignore event_in.
- R5: Writing 1 to bit i of address 4 advances event counter i by one, but only when that counter is enabled, the global enable is set, and its event code is 0.
- R6: Addresses 7 and 8 read and write the event code and the count of the counter chosen by address 5, bits 1..0.
- R7: Writing control bit 1 zeroes all event counters, and writing control bit 2 zeroes the cycle counter. These bits always read back as 0.
- R8: A counter that advances from all ones wraps to zero and sets its overflow flag at that same edge. Writing 1 to a flag bit at address 3 clears it, and writing 0 leaves it unchanged.
- R9: irq is high exactly when the global enable is set and some overflow flag has its interrupt enable set. Interrupt enables are set at address 10 and cleared at address 11.
- R10: While user_mode is high and the user-access bit (address 9, bit 0) is clear, any access raises bus_err, returns zero read data and changes no state. A user-mode write to address 9 is always refused in this way.
- R11: A bus write to a count register wins over an increment of that counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| bus_err | output | 1 | Access refused by the user-access gate |
| user_mode | input | 1 | Requester runs unprivileged |
| event_in | input | 8 | Event pulse lines, one cycle per event |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest situation to reach from the ports is a counter overflow. With 32-bit counters, natural counting cannot get there in a short run. The stimulus therefore preloads a counter to all ones through the indirect count register, or the cycle counter to two below wrap, and then applies exactly one software increment or a few enabled cycles. It then checks the flag, the wrapped value and the interrupt gating in the cycles that follow. Same-cycle collisions, such as a count load while an event pulse is active, are set up by holding the event line high across the bus write.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  typedef enum logic [3:0] {
    REG_CTRL    = 4'd0,
    REG_EN_SET  = 4'd1,
    REG_EN_CLR  = 4'd2,
    REG_OVF     = 4'd3,
    REG_SWINC   = 4'd4,
    REG_SEL     = 4'd5,
    REG_CYC     = 4'd6,
    REG_EVTYPE  = 4'd7,
    REG_EVCNT   = 4'd8,
    REG_USER    = 4'd9,
    REG_IE_SET  = 4'd10,
    REG_IE_CLR  = 4'd11
  } pmu_reg_e;

  localparam int ADDR_W    = 4;
  localparam int NUM_ADDR  = 1 << ADDR_W;
  localparam int CTRL_EN   = 0;
  localparam int CTRL_RSTE = 1;
  localparam int CTRL_RSTC = 2;

  // set bits win over clear bits only if both arrive together (never via one bus)
  function automatic logic [31:0] mask_update(input logic [31:0] cur,
                                              input logic [31:0] set_m,
                                              input logic [31:0] clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

  // a freshly wrapped counter keeps its flag even if cleared in the same cycle
  function automatic logic [31:0] flag_update(input logic [31:0] cur,
                                              input logic [31:0] clr_m,
                                              input logic [31:0] wraps);
    return (cur & ~clr_m) | wraps;
  endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = inc && !clr && !load && (cnt == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pmu_bus_dec.sv
module pmu_bus_dec
  import pmu_pkg::*;
(
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                user_mode,
  input  logic                user_en,
  output logic                blocked,
  output logic [NUM_ADDR-1:0] wr_stb
);
  logic user_deny;
  assign user_deny = user_mode && (!user_en || (bus_write && bus_addr == REG_USER));
  assign blocked   = bus_valid && user_deny;

  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_stb
    assign wr_stb[a] = bus_valid && bus_write && !user_deny && (bus_addr == ADDR_W'(a));
  end
endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 8,
  parameter int TYPE_W  = 8
) (
  input  logic [NUM_CNT-1:0][TYPE_W-1:0] evtype,
  input  logic [NUM_EVT-1:0]             events,
  input  logic [NUM_CNT-1:0]             swinc_req,
  output logic [NUM_CNT-1:0]             hit
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic hw_hit;
    always_comb begin
      hw_hit = 1'b0;
      for (int k = 0; k < NUM_EVT; k++) begin
        if (evtype[i] == TYPE_W'(k + 1) && events[k]) hw_hit = 1'b1;
      end
    end
    assign hit[i] = hw_hit || (swinc_req[i] && evtype[i] == '0);
  end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 8,
  parameter int CNT_W   = 32,
  parameter int TYPE_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              user_mode,
  input  logic [NUM_EVT-1:0] event_in,
  output logic              irq
);
  localparam int NCTR    = NUM_CNT + 1;
  localparam int CYC_IDX = NUM_CNT;
  localparam int SEL_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  // named internal state and events (observed by the checker)
  logic                             glob_en;
  logic [NCTR-1:0]                  cnten_q;
  logic [NCTR-1:0]                  inten_q;
  logic [NCTR-1:0]                  ovf_q;
  logic                             user_en_q;
  logic [SEL_W-1:0]                 sel_q;
  logic [NUM_CNT-1:0][TYPE_W-1:0]   evtype_q;
  logic [NUM_CNT-1:0][CNT_W-1:0]    ev_cnt;
  logic [CNT_W-1:0]                 cyc_cnt;
  logic [NCTR-1:0]                  wrap_vec;
  logic                             blocked;
  logic [NUM_ADDR-1:0]              wr_stb;
  logic [NUM_CNT-1:0]               evt_hit;
  logic [NUM_CNT-1:0]               swinc_req;
  logic                             rst_ev, rst_cyc;

  pmu_bus_dec u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .user_mode (user_mode),
    .user_en   (user_en_q),
    .blocked   (blocked),
    .wr_stb    (wr_stb)
  );

  assign swinc_req = wr_stb[REG_SWINC] ? bus_wdata[NUM_CNT-1:0] : '0;
  assign rst_ev    = wr_stb[REG_CTRL] && bus_wdata[CTRL_RSTE];
  assign rst_cyc   = wr_stb[REG_CTRL] && bus_wdata[CTRL_RSTC];

  pmu_evt_sel #(.NUM_CNT(NUM_CNT), .NUM_EVT(NUM_EVT), .TYPE_W(TYPE_W)) u_sel (
    .evtype    (evtype_q),
    .events    (event_in),
    .swinc_req (swinc_req),
    .hit       (evt_hit)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_ev
    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (rst_ev),
      .load     (wr_stb[REG_EVCNT] && sel_q == SEL_W'(i)),
      .load_val (bus_wdata[CNT_W-1:0]),
      .inc      (glob_en && cnten_q[i] && evt_hit[i]),
      .cnt      (ev_cnt[i]),
      .wrap     (wrap_vec[i])
    );
  end

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (rst_cyc),
    .load     (wr_stb[REG_CYC]),
    .load_val (bus_wdata[CNT_W-1:0]),
    .inc      (glob_en && cnten_q[CYC_IDX]),
    .cnt      (cyc_cnt),
    .wrap     (wrap_vec[CYC_IDX])
  );

  logic [31:0] en_set_m, en_clr_m, ie_set_m, ie_clr_m, ovf_clr_m, wrap_m;
  assign en_set_m  = wr_stb[REG_EN_SET] ? 32'(bus_wdata[NCTR-1:0]) : '0;
  assign en_clr_m  = wr_stb[REG_EN_CLR] ? 32'(bus_wdata[NCTR-1:0]) : '0;
  assign ie_set_m  = wr_stb[REG_IE_SET] ? 32'(bus_wdata[NCTR-1:0]) : '0;
  assign ie_clr_m  = wr_stb[REG_IE_CLR] ? 32'(bus_wdata[NCTR-1:0]) : '0;
  assign ovf_clr_m = wr_stb[REG_OVF]    ? 32'(bus_wdata[NCTR-1:0]) : '0;
  assign wrap_m    = 32'(wrap_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en   <= 1'b0;
      cnten_q   <= '0;
      inten_q   <= '0;
      ovf_q     <= '0;
      user_en_q <= 1'b0;
      sel_q     <= '0;
      evtype_q  <= '0;
    end else begin
      if (wr_stb[REG_CTRL]) glob_en <= bus_wdata[CTRL_EN];
      if (wr_stb[REG_USER]) user_en_q <= bus_wdata[0];
      if (wr_stb[REG_SEL])  sel_q <= bus_wdata[SEL_W-1:0];
      if (wr_stb[REG_EVTYPE]) evtype_q[sel_q] <= bus_wdata[TYPE_W-1:0];
      cnten_q <= NCTR'(mask_update(32'(cnten_q), en_set_m, en_clr_m));
      inten_q <= NCTR'(mask_update(32'(inten_q), ie_set_m, ie_clr_m));
      ovf_q   <= NCTR'(flag_update(32'(ovf_q), ovf_clr_m, wrap_m));
    end
  end

  assign irq     = glob_en && |(ovf_q & inten_q);
  assign bus_err = blocked;

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !blocked) begin
      case (bus_addr)
        REG_CTRL:   bus_rdata = DATA_W'(glob_en);
        REG_EN_SET,
        REG_EN_CLR: bus_rdata = DATA_W'(cnten_q);
        REG_OVF:    bus_rdata = DATA_W'(ovf_q);
        REG_SEL:    bus_rdata = DATA_W'(sel_q);
        REG_CYC:    bus_rdata = DATA_W'(cyc_cnt);
        REG_EVTYPE: bus_rdata = DATA_W'(evtype_q[sel_q]);
        REG_EVCNT:  bus_rdata = DATA_W'(ev_cnt[sel_q]);
        REG_USER:   bus_rdata = DATA_W'(user_en_q);
        REG_IE_SET,
        REG_IE_CLR: bus_rdata = DATA_W'(inten_q);
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_valid,
  input logic                     bus_write,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [NUM_CNT:0]         wdata_lo,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic                     bus_err,
  input logic                     user_mode,
  input logic                     irq,
  input logic                     glob_en,
  input logic [NUM_CNT:0]         cnten_q,
  input logic [NUM_CNT:0]         inten_q,
  input logic [NUM_CNT:0]         ovf_q,
  input logic                     user_en_q,
  input logic [NUM_CNT:0]         wrap_vec,
  input logic [CNT_W-1:0]         cyc_cnt,
  input logic [NUM_CNT*CNT_W-1:0] ev_cnt_flat
);
  logic good_wr;
  assign good_wr = bus_valid && bus_write && !bus_err;

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !irq);

  assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

  assert_user_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && user_mode && !user_en_q) |-> (bus_err && bus_rdata == '0));

  assert_refused_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_err) |=>
      ($stable(cnten_q) && $stable(inten_q) && $stable(user_en_q)));

  assert_en_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (good_wr && bus_addr == REG_EN_CLR) |=> ((cnten_q & $past(wdata_lo)) == '0));

  assert_cycle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !(bus_valid && bus_write)) |=> $stable(cyc_cnt));

  assert_event_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (good_wr && bus_addr == REG_CTRL && wdata_lo[CTRL_RSTE]) |=> (ev_cnt_flat == '0));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|ovf_q));
endmodule

bind perf_mon_unit pmu_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .wdata_lo    (bus_wdata[NUM_CNT:0]),
  .bus_rdata   (bus_rdata),
  .bus_err     (bus_err),
  .user_mode   (user_mode),
  .irq         (irq),
  .glob_en     (glob_en),
  .cnten_q     (cnten_q),
  .inten_q     (inten_q),
  .ovf_q       (ovf_q),
  .user_en_q   (user_en_q),
  .wrap_vec    (wrap_vec),
  .cyc_cnt     (cyc_cnt),
  .ev_cnt_flat (ev_cnt)
);

// File: tb/perf_mon_unit_tb_top.sv
module perf_mon_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, user_mode = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  event_in = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  perf_mon_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .user_mode(user_mode), .event_in(event_in), .irq(irq)
  );

  localparam logic [3:0] A_CTRL = 4'd0, A_ENS = 4'd1, A_ENC = 4'd2, A_OVF = 4'd3,
    A_SWI = 4'd4, A_SEL = 4'd5, A_CYC = 4'd6, A_TYP = 4'd7, A_CNT = 4'd8,
    A_USR = 4'd9, A_IES = 4'd10, A_IEC = 4'd11;

  typedef struct packed {
    logic        wr;
    logic        usr;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic        eerr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, A_CTRL, 32'h0,    32'h0,    1'b0, 4'd1},  // R1
    '{1'b0, 1'b0, A_ENS,  32'h0,    32'h0,    1'b0, 4'd1},  // R1
    '{1'b1, 1'b0, A_ENS,  32'h13,   32'h0,    1'b0, 4'd2},  // R2
    '{1'b0, 1'b0, A_ENC,  32'h0,    32'h13,   1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, A_ENC,  32'h02,   32'h0,    1'b0, 4'd2},
    '{1'b0, 1'b0, A_ENS,  32'h0,    32'h11,   1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, A_SEL,  32'h2,    32'h0,    1'b0, 4'd6},
    '{1'b1, 1'b0, A_TYP,  32'h5,    32'h0,    1'b0, 4'd6},
    '{1'b1, 1'b0, A_CNT,  32'h1234, 32'h0,    1'b0, 4'd6},
    '{1'b1, 1'b0, A_SEL,  32'h1,    32'h0,    1'b0, 4'd6},
    '{1'b0, 1'b0, A_CNT,  32'h0,    32'h0,    1'b0, 4'd6},  // R6
    '{1'b0, 1'b0, A_TYP,  32'h0,    32'h0,    1'b0, 4'd6},
    '{1'b1, 1'b0, A_SEL,  32'h2,    32'h0,    1'b0, 4'd6},
    '{1'b0, 1'b0, A_CNT,  32'h0,    32'h1234, 1'b0, 4'd6},
    '{1'b0, 1'b0, A_TYP,  32'h0,    32'h5,    1'b0, 4'd6},
    '{1'b1, 1'b0, A_CTRL, 32'h2,    32'h0,    1'b0, 4'd7},  // R7
    '{1'b0, 1'b0, A_CNT,  32'h0,    32'h0,    1'b0, 4'd7},
    '{1'b0, 1'b0, A_CTRL, 32'h0,    32'h0,    1'b0, 4'd7},
    '{1'b0, 1'b0, A_SEL,  32'h0,    32'h2,    1'b0, 4'd6},
    '{1'b1, 1'b0, A_ENC,  32'h1F,   32'h0,    1'b0, 4'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic usr, input logic [3:0] a,
                        input logic [31:0] d, output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; user_mode = usr; bus_addr = a; bus_wdata = d;
    #1;
    rd = bus_rdata; er = bus_err;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_write = 1'b0; user_mode = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    bus_op(1'b1, 1'b0, a, d, r, e);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] r; logic e;
    bus_op(1'b0, 1'b0, a, 32'h0, r, e);
    check(req, r, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r; logic e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 check("R1 irq", 32'(irq), 32'h0);
    rd_chk("R1 cycle", A_CYC, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_op(TBL[i].wr, TBL[i].usr, TBL[i].addr, TBL[i].data, r, e);
      if (TBL[i].wr) check($sformatf("R%0d err vec%0d", TBL[i].req, i), 32'(e), 32'(TBL[i].eerr));
      else           check($sformatf("R%0d rd vec%0d", TBL[i].req, i), r, TBL[i].exp);
    end

    // R3: cycle counter, enable asserted for N edges plus the disabling edge
    wr(A_CYC, 32'h0);
    wr(A_ENS, 32'h10);
    wr(A_CTRL, 32'h1);
    repeat (10) @(posedge clk);
    wr(A_CTRL, 32'h0);
    rd_chk("R3 cycle count", A_CYC, 32'd11);
    repeat (4) @(posedge clk);
    rd_chk("R3 cycle hold", A_CYC, 32'd11);

    // R4: event selection
    wr(A_SEL, 32'h0); wr(A_TYP, 32'h1);
    wr(A_SEL, 32'h1); wr(A_TYP, 32'h0);
    wr(A_SEL, 32'h2); wr(A_TYP, 32'h9); wr(A_CNT, 32'h0);
    wr(A_ENS, 32'h07);
    wr(A_CTRL, 32'h1);
    @(negedge clk); event_in = 8'hFF;
    repeat (3) @(negedge clk);
    event_in = 8'h00;
    wr(A_CTRL, 32'h0);
    wr(A_SEL, 32'h0); rd_chk("R4 code1 counts", A_CNT, 32'd3);
    wr(A_SEL, 32'h1); rd_chk("R4 code0 ignores events", A_CNT, 32'd0);
    wr(A_SEL, 32'h2); rd_chk("R4 code9 ignores events", A_CNT, 32'd0);

    // R5: software increment
    wr(A_CTRL, 32'h1);
    wr(A_SWI, 32'h0F);
    wr(A_CTRL, 32'h0);
    wr(A_SEL, 32'h0); rd_chk("R5 code1 no swinc", A_CNT, 32'd3);
    wr(A_SEL, 32'h1); rd_chk("R5 swinc counted", A_CNT, 32'd1);
    wr(A_SEL, 32'h3); rd_chk("R5 disabled no swinc", A_CNT, 32'd0);

    // R11: load beats increment
    wr(A_SEL, 32'h0);
    wr(A_CTRL, 32'h1);
    @(negedge clk); event_in = 8'h01;
    wr(A_CNT, 32'd100);
    rd_chk("R11 load priority", A_CNT, 32'd100);
    event_in = 8'h00;
    wr(A_CTRL, 32'h0);

    // R8 / R9: event counter overflow
    wr(A_SEL, 32'h3); wr(A_TYP, 32'h0); wr(A_CNT, 32'hFFFF_FFFF);
    wr(A_ENS, 32'h08); wr(A_IES, 32'h08);
    wr(A_CTRL, 32'h1);
    check("R9 irq no flag", 32'(irq), 32'h0);
    wr(A_SWI, 32'h08);
    check("R9 irq on overflow", 32'(irq), 32'h1);
    rd_chk("R8 flag set", A_OVF, 32'h08);
    rd_chk("R8 wrapped to zero", A_CNT, 32'h0);
    wr(A_CTRL, 32'h0);
    check("R9 irq global gate", 32'(irq), 32'h0);
    wr(A_CTRL, 32'h1);
    check("R9 irq regated", 32'(irq), 32'h1);
    wr(A_IEC, 32'h08);
    check("R9 irq ie cleared", 32'(irq), 32'h0);
    wr(A_CTRL, 32'h0);
    wr(A_OVF, 32'h00);
    rd_chk("R8 write0 keeps flag", A_OVF, 32'h08);
    wr(A_OVF, 32'h08);
    rd_chk("R8 write1 clears flag", A_OVF, 32'h00);

    // R8: cycle counter overflow, 6 increments from two below wrap
    wr(A_CYC, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h1);
    repeat (5) @(posedge clk);
    wr(A_CTRL, 32'h0);
    rd_chk("R8 cycle flag", A_OVF, 32'h10);
    rd_chk("R8 cycle wrap value", A_CYC, 32'd4);
    wr(A_CTRL, 32'h4);
    rd_chk("R7 cycle reset", A_CYC, 32'h0);

    // R10: user access gate (enable mask is now 0x1F)
    bus_op(1'b0, 1'b1, A_ENS, 32'h0, r, e);
    check("R10 user read err", 32'(e), 32'h1);
    check("R10 user read data", r, 32'h0);
    bus_op(1'b1, 1'b1, A_ENC, 32'h1F, r, e);
    check("R10 user write err", 32'(e), 32'h1);
    rd_chk("R10 user write ignored", A_ENS, 32'h1F);
    wr(A_USR, 32'h1);
    bus_op(1'b0, 1'b1, A_ENS, 32'h0, r, e);
    check("R10 user allowed err", 32'(e), 32'h0);
    check("R10 user allowed data", r, 32'h1F);
    bus_op(1'b1, 1'b1, A_USR, 32'h0, r, e);
    check("R10 user-access self write err", 32'(e), 32'h1);
    rd_chk("R10 user-access kept", A_USR, 32'h1);

    finish_run();
  end
endmodule